// File: doc/BRIEF.md
# Platform System Control Register Block

This block sits on a byte-wide, I/O-port style bus and serves a small group of platform ports. Some ports return fixed identification bytes describing the board. Others hold writable control fields: the endian mode, the I/O map mode, a disk-activity light and a four-bit system control field. A third group causes side effects elsewhere in the chip: a soft reset, two lock toggles for a non-volatile memory, and a cache invalidate. Each side effect is sent out as a one-clock pulse. A pair of scratch bytes completes the set.

The bus carries one address for both directions, plus a write strobe and a read strobe that are each one clock wide. A write takes effect on the clock edge where its strobe is sampled. Levels and pulses change right after that edge. A read is also sampled on a clock edge. Its byte is presented on the read data port for the following cycle, with a valid flag that is high only in that cycle. The bus has no back-pressure, because the block accepts every access on the cycle it arrives. The block does not sit in a data stream, so it has no valid/ready handshake. All outputs are plain levels or pulses.

Top module: `sysctl_regs_top`

## Requirements
- R1: After reset the endian, map-mode and light outputs are 0 and all pulse outputs are 0. Port 0x081C, port 0x0850 and both scratch ports read 0x00.
- R2: The following ports always return fixed bytes: 0x0092 returns 0x00, 0x0800 returns 0xEF, 0x0802 returns 0xAD, 0x0803 returns 0xE0, 0x080C returns 0x3C, 0x0810 returns 0x39, 0x0818 returns 0x00 and 0x0823 returns 0x03. Writes to 0x0800, 0x0802 and 0x0803 change nothing.
- R3: A read of any address not named in R2, R8, R9 or R10 returns 0xFF. This includes 0x0808, 0x0812 and 0x0814.
- R4: A write to 0x0092 sets the endian output to bit 1 of the data (1 = little-endian, 0 = big-endian).
- R5: A write to 0x0092 with bit 0 set gives a soft-reset pulse that lasts one clock. The pulse is high in the cycle after the write. A write with bit 0 clear gives no pulse.
- R6: Any write to 0x0810 pulses lock toggle 1, any write to 0x0812 pulses lock toggle 2, and any write to 0x0814 pulses cache invalidate. Each pulse lasts one clock, starts in the cycle after the write, and does not depend on the data. Writes to any other address raise none of the four pulses.
- R7: A write to 0x0808 sets the light output to bit 0 of the data.
- R8: A write to 0x081C stores bits 3:0 of the data. A read of 0x081C returns the stored bits with bits 7:4 as zero.
- R9: A write to 0x0850 stores bit 0 as the I/O map mode (0 = contiguous, 1 = non-contiguous). The stored bit drives the map-mode output, and a read of 0x0850 returns it in bit 0 with bits 7:1 as zero.
- R10: Ports 0x0398 and 0x0399 each return the last full byte written to them, independently of each other.
- R11: The read byte and a valid flag appear in the cycle after the read strobe. The valid flag is low in every cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Port address for a read or write |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one clock per read |
| bus_rdata | output | 8 | Read data, valid in the cycle after the read strobe |
| bus_rvalid | output | 1 | High for one cycle when bus_rdata carries a read result |
| mode_little_endian | output | 1 | Endian mode level, 1 = little-endian |
| mode_io_noncontig | output | 1 | I/O map mode level, 1 = non-contiguous |
| disk_light | output | 1 | Disk-activity light level |
| soft_reset_pulse | output | 1 | One-clock soft-reset request |
| nvlock1_toggle | output | 1 | One-clock toggle for lock 1 |
| nvlock2_toggle | output | 1 | One-clock toggle for lock 2 |
| cache_inval | output | 1 | One-clock cache invalidate request |

## Verification
The bench reads every address from 0x0000 to 0x0FFF and checks each result against a model. A decoder that matched too few address bits, or left a gap, would return an ID byte or stale storage where 0xFF belongs. Every data byte from 0 to 255 is written to the endian, map, light and control-field ports. A design that stored a masked-off bit, or used the wrong bit for a mode, would fail at the first value that exercises that bit. After each write the bench samples the pulse outputs in the cycle after the write and again one cycle later. This catches a pulse that lasts more than one clock, starts a cycle late, fires for bit 0 clear on 0x0092, or fires from the wrong address. Writes to the read-only ID ports and to one scratch byte are followed by reads of the neighbouring bytes, which catches aliasing.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned DW = 8;

  // Port addresses; the decode and the read-back depend on these values.
  localparam logic [15:0] PA_SPECIAL = 16'h0092;
  localparam logic [15:0] PA_CPUCFG  = 16'h0800;
  localparam logic [15:0] PA_FEAT    = 16'h0802;
  localparam logic [15:0] PA_STAT    = 16'h0803;
  localparam logic [15:0] PA_LIGHT   = 16'h0808;
  localparam logic [15:0] PA_EQUIP   = 16'h080C;
  localparam logic [15:0] PA_LOCK1   = 16'h0810;
  localparam logic [15:0] PA_LOCK2   = 16'h0812;
  localparam logic [15:0] PA_INVAL   = 16'h0814;
  localparam logic [15:0] PA_KEY     = 16'h0818;
  localparam logic [15:0] PA_SYSCTL  = 16'h081C;
  localparam logic [15:0] PA_CACHEID = 16'h0823;
  localparam logic [15:0] PA_MAP     = 16'h0850;
  localparam logic [15:0] PA_SCRATCH = 16'h0398;

  // Fixed identification bytes.
  localparam logic [DW-1:0] ID_CPUCFG  = 8'hEF;
  localparam logic [DW-1:0] ID_FEAT    = 8'hAD;
  localparam logic [DW-1:0] ID_STAT    = 8'hE0;
  localparam logic [DW-1:0] ID_EQUIP   = 8'h3C;
  localparam logic [DW-1:0] ID_XFEAT   = 8'h39;
  localparam logic [DW-1:0] ID_CACHEID = 8'h03;
  localparam logic [DW-1:0] RD_UNMAPPED = 8'hFF;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SPECIAL, SEL_CPUCFG, SEL_FEAT, SEL_STAT, SEL_LIGHT,
    SEL_EQUIP, SEL_LOCK1, SEL_LOCK2, SEL_INVAL, SEL_KEY, SEL_SYSCTL,
    SEL_CACHEID, SEL_MAP
  } port_sel_e;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SCRATCH_N = 2,
  localparam int unsigned SCR_IDX_W = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output port_sel_e            sel_o,
  output logic                 scr_hit_o,
  output logic [SCR_IDX_W-1:0] scr_idx_o
);
  localparam logic [ADDR_W-1:0] SCR_BASE = ADDR_W'(PA_SCRATCH);
  localparam logic [ADDR_W-1:0] SCR_END  = ADDR_W'(PA_SCRATCH) + ADDR_W'(SCRATCH_N);

  logic [ADDR_W-1:0] scr_off;

  always_comb begin
    unique case (addr_i)
      ADDR_W'(PA_SPECIAL): sel_o = SEL_SPECIAL;
      ADDR_W'(PA_CPUCFG):  sel_o = SEL_CPUCFG;
      ADDR_W'(PA_FEAT):    sel_o = SEL_FEAT;
      ADDR_W'(PA_STAT):    sel_o = SEL_STAT;
      ADDR_W'(PA_LIGHT):   sel_o = SEL_LIGHT;
      ADDR_W'(PA_EQUIP):   sel_o = SEL_EQUIP;
      ADDR_W'(PA_LOCK1):   sel_o = SEL_LOCK1;
      ADDR_W'(PA_LOCK2):   sel_o = SEL_LOCK2;
      ADDR_W'(PA_INVAL):   sel_o = SEL_INVAL;
      ADDR_W'(PA_KEY):     sel_o = SEL_KEY;
      ADDR_W'(PA_SYSCTL):  sel_o = SEL_SYSCTL;
      ADDR_W'(PA_CACHEID): sel_o = SEL_CACHEID;
      ADDR_W'(PA_MAP):     sel_o = SEL_MAP;
      default:             sel_o = SEL_NONE;
    endcase
  end

  assign scr_off   = addr_i - SCR_BASE;
  assign scr_hit_o = (addr_i >= SCR_BASE) && (addr_i < SCR_END);
  assign scr_idx_o = scr_off[SCR_IDX_W-1:0];
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int unsigned SCRATCH_N = 2,
  parameter int unsigned SYSCTL_W  = 4,
  localparam int unsigned SCR_IDX_W = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  port_sel_e                     sel_i,
  input  logic                          scr_hit_i,
  input  logic [SCR_IDX_W-1:0]          scr_idx_i,
  input  logic [DW-1:0]                 wdata_i,
  output logic                          le_o,
  output logic                          noncontig_o,
  output logic                          light_o,
  output logic [SYSCTL_W-1:0]           sysctl_o,
  output logic [SCRATCH_N-1:0][DW-1:0]  scr_o,
  output logic                          soft_rst_o,
  output logic                          lock1_o,
  output logic                          lock2_o,
  output logic                          inval_o
);
  // Control levels
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      le_o        <= 1'b0;
      noncontig_o <= 1'b0;
      light_o     <= 1'b0;
      sysctl_o    <= '0;
    end else if (wr_en_i) begin
      unique case (sel_i)
        SEL_SPECIAL: le_o        <= wdata_i[1];
        SEL_MAP:     noncontig_o <= wdata_i[0];
        SEL_LIGHT:   light_o     <= wdata_i[0];
        SEL_SYSCTL:  sysctl_o    <= wdata_i[SYSCTL_W-1:0];
        default: ;
      endcase
    end
  end

  // Side-effect pulses, each one clock after the accepted write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soft_rst_o <= 1'b0;
      lock1_o    <= 1'b0;
      lock2_o    <= 1'b0;
      inval_o    <= 1'b0;
    end else begin
      soft_rst_o <= wr_en_i && (sel_i == SEL_SPECIAL) && wdata_i[0];
      lock1_o    <= wr_en_i && (sel_i == SEL_LOCK1);
      lock2_o    <= wr_en_i && (sel_i == SEL_LOCK2);
      inval_o    <= wr_en_i && (sel_i == SEL_INVAL);
    end
  end

  // Scratch bytes
  for (genvar g = 0; g < SCRATCH_N; g++) begin : g_scr
    always_ff @(posedge clk) begin
      if (!rst_n) scr_o[g] <= '0;
      else if (wr_en_i && scr_hit_i && (scr_idx_i == SCR_IDX_W'(g))) scr_o[g] <= wdata_i;
    end
  end

  a_r6_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({soft_rst_o, lock1_o, lock2_o, inval_o}));
  a_r5_soft_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> $past(wr_en_i && (sel_i == SEL_SPECIAL) && wdata_i[0]));
  a_r4_endian_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en_i && (sel_i == SEL_SPECIAL)) |-> $stable(le_o));
  a_r9_map_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en_i && (sel_i == SEL_MAP)) |-> $stable(noncontig_o));
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int unsigned SCRATCH_N = 2,
  parameter int unsigned SYSCTL_W  = 4,
  localparam int unsigned SCR_IDX_W = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en_i,
  input  port_sel_e                     sel_i,
  input  logic                          scr_hit_i,
  input  logic [SCR_IDX_W-1:0]          scr_idx_i,
  input  logic                          noncontig_i,
  input  logic [SYSCTL_W-1:0]           sysctl_i,
  input  logic [SCRATCH_N-1:0][DW-1:0]  scr_i,
  output logic [DW-1:0]                 rdata_o,
  output logic                          rvalid_o
);
  logic [DW-1:0] rd_next;

  always_comb begin
    if (scr_hit_i) begin
      rd_next = scr_i[scr_idx_i];
    end else begin
      unique case (sel_i)
        SEL_SPECIAL: rd_next = '0;
        SEL_CPUCFG:  rd_next = ID_CPUCFG;
        SEL_FEAT:    rd_next = ID_FEAT;
        SEL_STAT:    rd_next = ID_STAT;
        SEL_EQUIP:   rd_next = ID_EQUIP;
        SEL_LOCK1:   rd_next = ID_XFEAT;
        SEL_KEY:     rd_next = '0;
        SEL_SYSCTL:  rd_next = DW'(sysctl_i);
        SEL_CACHEID: rd_next = ID_CACHEID;
        SEL_MAP:     rd_next = DW'(noncontig_i);
        default:     rd_next = RD_UNMAPPED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_next;
    end
  end

  a_r11_valid_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid_o |-> $past(rd_en_i));
  a_r3_unmapped_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid_o && $past(sel_i == SEL_NONE && !scr_hit_i)) |-> (rdata_o == RD_UNMAPPED));
  a_r8_field_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid_o && $past(sel_i == SEL_SYSCTL && !scr_hit_i)) |-> ((rdata_o >> SYSCTL_W) == '0));
endmodule

// File: rtl/sysctl_regs_top.sv
module sysctl_regs_top
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SCRATCH_N = 2,
  parameter int unsigned SYSCTL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid,
  output logic              mode_little_endian,
  output logic              mode_io_noncontig,
  output logic              disk_light,
  output logic              soft_reset_pulse,
  output logic              nvlock1_toggle,
  output logic              nvlock2_toggle,
  output logic              cache_inval
);
  localparam int unsigned SCR_IDX_W = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1;

  port_sel_e                    sel;
  logic                         scr_hit;
  logic [SCR_IDX_W-1:0]         scr_idx;
  logic [SYSCTL_W-1:0]          sysctl;
  logic [SCRATCH_N-1:0][DW-1:0] scr;

  sysctl_decode #(.ADDR_W(ADDR_W), .SCRATCH_N(SCRATCH_N)) u_decode (
    .addr_i(bus_addr), .sel_o(sel), .scr_hit_o(scr_hit), .scr_idx_o(scr_idx)
  );

  sysctl_store #(.SCRATCH_N(SCRATCH_N), .SYSCTL_W(SYSCTL_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en_i(bus_wr), .sel_i(sel),
    .scr_hit_i(scr_hit), .scr_idx_i(scr_idx), .wdata_i(bus_wdata),
    .le_o(mode_little_endian), .noncontig_o(mode_io_noncontig),
    .light_o(disk_light), .sysctl_o(sysctl), .scr_o(scr),
    .soft_rst_o(soft_reset_pulse), .lock1_o(nvlock1_toggle),
    .lock2_o(nvlock2_toggle), .inval_o(cache_inval)
  );

  sysctl_rdmux #(.SCRATCH_N(SCRATCH_N), .SYSCTL_W(SYSCTL_W)) u_rdmux (
    .clk(clk), .rst_n(rst_n), .rd_en_i(bus_rd), .sel_i(sel),
    .scr_hit_i(scr_hit), .scr_idx_i(scr_idx), .noncontig_i(mode_io_noncontig),
    .sysctl_i(sysctl), .scr_i(scr), .rdata_o(bus_rdata), .rvalid_o(bus_rvalid)
  );

  a_r7_light_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr && bus_addr == ADDR_W'(PA_LIGHT)) |-> $stable(disk_light));
  a_r6_lock1_cause: assert property (@(posedge clk) disable iff (!rst_n)
    nvlock1_toggle |-> $past(bus_wr && bus_addr == ADDR_W'(PA_LOCK1)));
endmodule

// File: tb/test_sysctl_regs_top.sv
module test_sysctl_regs_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic        le, nc, light, srst, lk1, lk2, inv;

  int n_chk = 0;
  int n_fail = 0;

  // bench model of writable state
  logic [3:0] m_sys = '0;
  logic       m_map = 1'b0;
  logic [7:0] m_scr0 = '0, m_scr1 = '0;
  logic [3:0] p_seen;

  always #2 clk = ~clk;

  sysctl_regs_top i_sysctl_regs_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .mode_little_endian(le), .mode_io_noncontig(nc),
    .disk_light(light), .soft_reset_pulse(srst), .nvlock1_toggle(lk1),
    .nvlock2_toggle(lk2), .cache_inval(inv)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    case (a)
      16'h0092: return 8'h00;
      16'h0800: return 8'hEF;
      16'h0802: return 8'hAD;
      16'h0803: return 8'hE0;
      16'h080C: return 8'h3C;
      16'h0810: return 8'h39;
      16'h0818: return 8'h00;
      16'h0823: return 8'h03;
      16'h081C: return {4'h0, m_sys};
      16'h0850: return {7'h0, m_map};
      16'h0398: return m_scr0;
      16'h0399: return m_scr1;
      default:  return 8'hFF;
    endcase
  endfunction

  // write; p_seen = pulses in the cycle after the write, then checks they drop
  task automatic do_wr(input logic [15:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    p_seen = {srst, lk1, lk2, inv};
    @(negedge clk);
    chk({req, " pulse one clock"}, {srst, lk1, lk2, inv}, 0);
  endtask

  task automatic do_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R11 rvalid after strobe", bus_rvalid, 1);
    d = bus_rdata;
    @(negedge clk);
    chk("R11 rvalid low when idle", bus_rvalid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 levels", {le, nc, light}, 0);
    chk("R1 pulses", {srst, lk1, lk2, inv}, 0);
    do_rd(16'h081C, r); chk("R1 field", r, 0);
    do_rd(16'h0850, r); chk("R1 map", r, 0);
    do_rd(16'h0398, r); chk("R1 scratch0", r, 0);
    do_rd(16'h0399, r); chk("R1 scratch1", r, 0);

    // R2/R3 full read sweep of the low 4 KB
    for (int a = 0; a < 4096; a++) begin
      do_rd(16'(a), r);
      chk($sformatf("R2 R3 read 0x%0h", a), r, exp_rd(16'(a)));
    end

    // R4/R5 all data values to 0x0092
    for (int v = 0; v < 256; v++) begin
      do_wr(16'h0092, 8'(v), "R5");
      chk("R5 soft reset pulse", p_seen, (v & 1) ? 4'b1000 : 4'b0000);
      chk("R4 endian", le, (v >> 1) & 1);
      do_rd(16'h0092, r); chk("R2 0x0092 reads zero", r, 0);
    end

    // R7 light, R8 field, R9 map over all values
    for (int v = 0; v < 256; v++) begin
      do_wr(16'h0808, 8'(v), "R7");
      chk("R7 light", light, v & 1);
      chk("R6 no pulse from light write", p_seen, 0);
      do_wr(16'h081C, 8'(v), "R8"); m_sys = 4'(v);
      do_rd(16'h081C, r); chk("R8 field readback", r, v & 15);
      do_wr(16'h0850, 8'(v), "R9"); m_map = v[0];
      chk("R9 map level", nc, v & 1);
      do_rd(16'h0850, r); chk("R9 map readback", r, v & 1);
    end

    // R6 pulses, data independent
    foreach (p_seen[i]) begin end
    for (int v = 0; v < 256; v += 85) begin
      do_wr(16'h0810, 8'(v), "R6"); chk("R6 lock1", p_seen, 4'b0100);
      do_wr(16'h0812, 8'(v), "R6"); chk("R6 lock2", p_seen, 4'b0010);
      do_wr(16'h0814, 8'(v), "R6"); chk("R6 invalidate", p_seen, 4'b0001);
      do_wr(16'h0816, 8'(v), "R6"); chk("R6 neighbour silent", p_seen, 4'b0000);
    end
    do_rd(16'h0810, r); chk("R2 0x0810 after write", r, 8'h39);

    // R2 writes to ID ports ignored
    do_wr(16'h0800, 8'h00, "R2");
    do_wr(16'h0802, 8'h11, "R2");
    do_wr(16'h0803, 8'hFF, "R2");
    do_rd(16'h0800, r); chk("R2 0x0800 write ignored", r, 8'hEF);
    do_rd(16'h0802, r); chk("R2 0x0802 write ignored", r, 8'hAD);
    do_rd(16'h0803, r); chk("R2 0x0803 write ignored", r, 8'hE0);

    // R10 scratch pair independence
    for (int v = 0; v < 256; v += 17) begin
      do_wr(16'h0398, 8'(v), "R10"); m_scr0 = 8'(v);
      do_wr(16'h0399, 8'(255 - v), "R10"); m_scr1 = 8'(255 - v);
      do_rd(16'h0398, r); chk("R10 scratch0", r, m_scr0);
      do_rd(16'h0399, r); chk("R10 scratch1", r, m_scr1);
    end
    do_rd(16'h039A, r); chk("R3 past scratch pair", r, 8'hFF);
    do_rd(16'h0397, r); chk("R3 before scratch pair", r, 8'hFF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule